// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs the external bus cycles of a controller whose single 8-bit port carries two things in turn: the low byte of a memory address, and then the data. An address-latch strobe is produced for an external transparent latch. While the strobe is high the port drives the low address byte. Once the strobe falls the port carries data. On a write the sequencer drives the write data. On a read it releases the port and samples what the external device returns. Software has no path to the port value. Only the sequencer decides what the port drives.

The strobe period is four oscillator cycles and its high time is one and a half oscillator cycles, so the block needs half-cycle resolution. The block is therefore clocked at twice the oscillator rate. Each strobe period is eight clock phases, numbered 0 to 7. The strobe runs freely and does not wait for requests. Requests arrive on a valid/ready channel:
- `req_ready` is high only in phase 7.
- A request offered at other times is back-pressured. The requester must hold `req_valid` and the payload steady until it sees `req_ready`.
- An accepted request occupies the whole next period.

Results return on a response channel that has no ready. `rsp_valid` is a one-clock pulse and cannot be stalled. `rsp_rdata` holds the last read value until the next read completes.

Top module: `mux_bus_seq`

## Requirements
- R1: After reset is released, `addr_strobe` repeats with a period of 8 clocks (four oscillator cycles), whether or not any request is pending.
- R2: In each period `addr_strobe` is high for exactly 3 clocks (phases 0, 1 and 2) and low for the remaining 5 clocks. The first clock after reset release is phase 0.
- R3: While `rst` is high, the outputs take these values: `addr_strobe` = 1, `port_out` = 8'hFF, `port_oe` = 1, `req_ready` = 0 and `rsp_valid` = 0. Any cycle in progress is abandoned.
- R4: `req_ready` is high only in phase 7. A request transfers on a clock where `req_valid` and `req_ready` are both high. Its bus cycle occupies phases 0 to 7 of the period that follows.
- R5: In phases 0 to 2 of an active bus cycle, `port_out` equals `req_addr[7:0]` of the accepted request and `port_oe` is 1.
- R6: In phases 3 to 7 of an active write cycle (`req_write` = 1), `port_out` equals the accepted `req_wdata` and `port_oe` is 1.
- R7: In phases 3 to 7 of an active read cycle (`req_write` = 0), `port_oe` is 0 and `port_out` is 8'hFF. The value on `port_in` in phase 7 is captured into `rsp_rdata`. `rsp_rdata` keeps that value until the next read completes, and write cycles leave it unchanged.
- R8: `rsp_valid` is high for exactly one clock, in phase 0 of the period after each bus cycle. With back-to-back requests that clock is the same one in which the next cycle drives its address.
- R9: In a period with no accepted request, `port_oe` is 0, `port_out` is 8'hFF and no `rsp_valid` pulse follows. The strobe still pulses as in R1 and R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the oscillator rate |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted this clock (phase 7) |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Memory address; only the low byte goes on the port |
| req_wdata | input | 8 | Write data |
| port_in | input | 8 | Value sensed on the shared port |
| port_out | output | 8 | Value the port drives |
| port_oe | output | 1 | Port output enable |
| addr_strobe | output | 1 | Address-latch strobe |
| rsp_valid | output | 1 | One-clock bus-cycle completion pulse |
| rsp_rdata | output | 8 | Last captured read data |

## Verification
The two functions that share a clock are the completion pulse of one bus cycle and the address phase of the next. When requests run back to back, `rsp_valid` rises in the same clock in which `port_out` switches to the new address. If the earlier cycle was a read, `rsp_rdata` changes in that same clock too. The bench provokes this overlap by offering requests with no gap: read after read, write after read, and read after write. A behavioural model predicts the pulse, the captured byte and the port value for every clock, and the bench compares all three against the outputs. A reset asserted in the middle of a cycle shows that the abandoned cycle produces no pulse.

// File: rtl/mux_bus_pkg.sv
package mux_bus_pkg;

  // What the port drives in the current phase
  typedef enum logic [1:0] {
    DRV_IDLE    = 2'd0,
    DRV_ADDR    = 2'd1,
    DRV_WDATA   = 2'd2,
    DRV_RELEASE = 2'd3
  } drv_sel_e;

endpackage

// File: rtl/mux_bus_phase.sv
module mux_bus_phase #(
  parameter int PERIOD_PH = 8,
  parameter int STROBE_PH = 3,
  localparam int PH_W = $clog2(PERIOD_PH)
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PH_W-1:0] phase,
  output logic            strobe,
  output logic            last_ph
);

  localparam logic [PH_W-1:0] LAST = PH_W'(PERIOD_PH - 1);
  localparam logic [PH_W-1:0] HIGH_END = PH_W'(STROBE_PH);

  logic [PH_W-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= '0;
    end else if (phase_q == LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign phase   = phase_q;
  assign last_ph = (phase_q == LAST) && !rst;
  assign strobe  = rst || (phase_q < HIGH_END);

  // R4: the phase after the last one starts a new period
  a_r4_wrap : assert property (@(posedge clk) disable iff (rst)
    last_ph |=> (phase == '0));

endmodule

// File: rtl/mux_bus_cycle.sv
module mux_bus_cycle #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              last_ph,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_addr_lo,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] port_in,
  output logic              active,
  output logic              is_write,
  output logic [DATA_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic              done,
  output logic [DATA_W-1:0] rdata
);

  logic take;
  logic finish;

  assign take   = req_valid && last_ph;
  assign finish = active && last_ph;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      is_write <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      done     <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= finish;
      if (finish && !is_write) begin
        rdata <= port_in;
      end
      if (last_ph) begin
        active <= take;
        if (take) begin
          is_write <= req_write;
          addr_q   <= req_addr_lo;
          wdata_q  <= req_wdata;
        end
      end
    end
  end

  // R8: completion pulse lasts a single clock
  a_r8_done_single : assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R4: an accepted request makes the next period an active cycle
  a_r4_take_starts : assert property (@(posedge clk) disable iff (rst)
    take |=> active);

  // R7: a write completion leaves the captured read data untouched
  a_r7_write_keeps : assert property (@(posedge clk) disable iff (rst)
    (finish && is_write) |=> $stable(rdata));

endmodule

// File: rtl/mux_bus_port.sv
module mux_bus_port
  import mux_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PH_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              active,
  input  logic              is_write,
  input  logic [DATA_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe
);

  drv_sel_e sel;

  always_comb begin
    if (!active) begin
      sel = DRV_IDLE;
    end else if (strobe) begin
      sel = DRV_ADDR;
    end else if (is_write) begin
      sel = DRV_WDATA;
    end else begin
      sel = DRV_RELEASE;
    end
  end

  always_comb begin
    port_out = '1;
    port_oe  = 1'b0;
    if (rst) begin
      port_out = '1;
      port_oe  = 1'b1;
    end else begin
      case (sel)
        DRV_ADDR: begin
          port_out = addr_q;
          port_oe  = 1'b1;
        end
        DRV_WDATA: begin
          port_out = wdata_q;
          port_oe  = 1'b1;
        end
        default: begin
          port_out = '1;
          port_oe  = 1'b0;
        end
      endcase
    end
  end

  // R5: the address is only ever driven while the strobe is high
  a_r5_addr_in_strobe : assert property (@(posedge clk) disable iff (rst)
    (sel == DRV_ADDR) |-> (strobe && port_oe));

  // R7: the port is never released while the strobe is high
  a_r7_release_after : assert property (@(posedge clk) disable iff (rst)
    (!port_oe) |-> (!strobe || !active));

endmodule

// File: rtl/mux_bus_seq.sv
module mux_bus_seq #(
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int PERIOD_PH = 8,
  parameter int STROBE_PH = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] port_in,
  output logic [DATA_W-1:0] port_out,
  output logic              port_oe,
  output logic              addr_strobe,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  localparam int PH_W  = $clog2(PERIOD_PH);
  localparam int CNT_W = PH_W + 2;

  logic [PH_W-1:0]   phase;
  logic              strobe;
  logic              last_ph;
  logic              active;
  logic              is_write;
  logic [DATA_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  mux_bus_phase #(
    .PERIOD_PH (PERIOD_PH),
    .STROBE_PH (STROBE_PH)
  ) u_phase (
    .clk     (clk),
    .rst     (rst),
    .phase   (phase),
    .strobe  (strobe),
    .last_ph (last_ph)
  );

  mux_bus_cycle #(
    .DATA_W (DATA_W)
  ) u_cycle (
    .clk         (clk),
    .rst         (rst),
    .last_ph     (last_ph),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr_lo (req_addr[DATA_W-1:0]),
    .req_wdata   (req_wdata),
    .port_in     (port_in),
    .active      (active),
    .is_write    (is_write),
    .addr_q      (addr_q),
    .wdata_q     (wdata_q),
    .done        (rsp_valid),
    .rdata       (rsp_rdata)
  );

  mux_bus_port #(
    .DATA_W (DATA_W),
    .PH_W   (PH_W)
  ) u_port (
    .clk      (clk),
    .rst      (rst),
    .strobe   (strobe),
    .active   (active),
    .is_write (is_write),
    .addr_q   (addr_q),
    .wdata_q  (wdata_q),
    .port_out (port_out),
    .port_oe  (port_oe)
  );

  assign req_ready   = last_ph;
  assign addr_strobe = strobe;

  // Strobe timing monitor: counters measure period and high time
  logic             strobe_d;
  logic             seen_rise;
  logic [CNT_W-1:0] per_cnt;
  logic [CNT_W-1:0] hi_cnt;
  logic             rise_now;
  logic             fall_now;

  assign rise_now = addr_strobe && !strobe_d;
  assign fall_now = !addr_strobe && strobe_d;

  always_ff @(posedge clk) begin
    strobe_d <= addr_strobe;
    if (rst) begin
      seen_rise <= 1'b0;
      per_cnt   <= '0;
      hi_cnt    <= '0;
    end else begin
      if (rise_now) begin
        seen_rise <= 1'b1;
        per_cnt   <= CNT_W'(1);
      end else if (per_cnt != '1) begin
        per_cnt <= per_cnt + 1'b1;
      end
      if (addr_strobe) begin
        if (rise_now) begin
          hi_cnt <= CNT_W'(1);
        end else if (hi_cnt != '1) begin
          hi_cnt <= hi_cnt + 1'b1;
        end
      end
    end
  end

  // R1: rises are exactly one period apart
  a_r1_period : assert property (@(posedge clk) disable iff (rst)
    (rise_now && seen_rise) |-> (per_cnt == CNT_W'(PERIOD_PH)));

  // R2: each high span lasts the strobe width
  a_r2_high_time : assert property (@(posedge clk) disable iff (rst)
    (fall_now && seen_rise) |-> (hi_cnt == CNT_W'(STROBE_PH)));

  // R3: reset forces strobe high and the port to all ones, driven
  a_r3_reset_drive : assert property (@(posedge clk)
    rst |-> (addr_strobe && port_oe && (&port_out) && !req_ready && !rsp_valid));

  // R4: ready only in the clock before the strobe rises
  a_r4_ready_edge : assert property (@(posedge clk) disable iff (rst)
    req_ready |=> $rose(addr_strobe));

endmodule

// File: tb/tb_mux_bus_seq.sv
module tb_mux_bus_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic       req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic [7:0] port_in = 8'h00;
  logic [7:0] port_out;
  logic       port_oe;
  logic       addr_strobe;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;

  always #10 clk = ~clk;

  mux_bus_seq dut (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .port_in     (port_in),
    .port_out    (port_out),
    .port_oe     (port_oe),
    .addr_strobe (addr_strobe),
    .rsp_valid   (rsp_valid),
    .rsp_rdata   (rsp_rdata)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Behavioural reference state
  int       m_phase = 0;
  bit       m_active = 0;
  bit       m_write = 0;
  bit [7:0] m_addr = 0;
  bit [7:0] m_wdata = 0;
  bit       m_done = 0;
  bit [7:0] m_rdata = 0;
  bit       stop_model = 0;

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!stop_model) begin
      bit [7:0] e_out;
      bit       e_oe;
      bit       e_strobe;
      string    ptag;
      cycles++;
      if (rst) begin
        check("R3", "strobe", addr_strobe, 1);
        check("R3", "port_out", port_out, 8'hFF);
        check("R3", "port_oe", port_oe, 1);
        check("R3", "req_ready", req_ready, 0);
        check("R3", "rsp_valid", rsp_valid, 0);
      end else begin
        e_strobe = (m_phase < 3);
        if (!m_active) begin
          e_out = 8'hFF; e_oe = 0; ptag = "R9";
        end else if (m_phase < 3) begin
          e_out = m_addr; e_oe = 1; ptag = "R5";
        end else if (m_write) begin
          e_out = m_wdata; e_oe = 1; ptag = "R6";
        end else begin
          e_out = 8'hFF; e_oe = 0; ptag = "R7";
        end
        check(e_strobe ? "R1" : "R2", "strobe", addr_strobe, e_strobe);
        check(ptag, "port_out", port_out, e_out);
        check(ptag, "port_oe", port_oe, e_oe);
        check("R4", "req_ready", req_ready, (m_phase == 7));
        check("R8", "rsp_valid", rsp_valid, m_done);
        check("R7", "rsp_rdata", rsp_rdata, m_rdata);
      end
      // advance the model to the state after the next rising edge
      if (rst) begin
        m_phase = 0; m_active = 0; m_done = 0; m_rdata = 0;
        m_write = 0; m_addr = 0; m_wdata = 0;
      end else begin
        m_done = m_active && (m_phase == 7);
        if (m_active && m_phase == 7 && !m_write) m_rdata = port_in;
        if (m_phase == 7) begin
          m_active = req_valid;
          if (req_valid) begin
            m_write = req_write; m_addr = req_addr[7:0]; m_wdata = req_wdata;
          end
        end
        m_phase = (m_phase + 1) % 8;
      end
    end
  end

  // port_in changes every clock so a wrong sampling phase is visible
  always @(posedge clk) begin
    #1 port_in <= port_in * 8'd5 + 8'd3;
  end

  task automatic issue(input bit wr, input logic [15:0] a, input logic [7:0] d);
    bit hand;
    hand = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!hand) begin
      @(negedge clk);
      hand = req_ready;
      @(posedge clk);
      #1;
    end
    req_valid = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  initial begin
    wait_clk(6);
    rst = 0;
    wait_clk(20);
    // single write, then single read (R5, R6, R7, R8)
    issue(1, 16'h12A5, 8'h3C);
    wait_clk(12);
    issue(0, 16'h0F5A, 8'h00);
    wait_clk(9);
    // back-to-back: read, read, write, read (R8 overlap, R7 hold)
    issue(0, 16'h0011, 8'h00);
    issue(0, 16'h0022, 8'h00);
    issue(1, 16'h0033, 8'hC3);
    issue(0, 16'h0044, 8'h00);
    wait_clk(3);
    // write after read keeps read data (R7), then idle periods (R9)
    issue(1, 16'h0055, 8'h99);
    wait_clk(30);
    // reset during an active read cycle (R3)
    issue(0, 16'h0066, 8'h00);
    wait_clk(4);
    rst = 1;
    wait_clk(3);
    rst = 0;
    wait_clk(10);
    issue(1, 16'h00FF, 8'h00);
    issue(0, 16'hAB00, 8'h00);
    wait_clk(20);
    stop_model = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    stop_model = 1;
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", cycles, 5000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule